// File: doc/BRIEF.md
# Sleep Entry and Exit Sequencer with Retained Storage

This block fronts a small synchronous storage array and manages a low-power sleep state for it. An external, asynchronous, active-high request asks for sleep. The request passes through a synchroniser. A short entry delay then follows. Once asleep, the block refuses every command, forces its result outputs off and holds all internal state, including the array contents and any result still waiting to be taken.

When the request falls, the block starts a fixed wake-up window. In that window only deselect and read commands are legal. A write offered in the window is dropped and recorded in a sticky error flag. Sleep should be requested only after outstanding operations have finished, because work that is in flight at the moment of the request is not guaranteed to complete.

Commands enter on a valid/ready channel. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. Read results leave on a second valid/ready channel. A result stays on `rsp_valid`/`rsp_data` until a rising edge that sees `rsp_ready` high. While a result is waiting and `rsp_ready` is low, `cmd_ready` is low.

Top module: `sleep_seq`

## Requirements
- R1: After reset, `asleep`, `recovering`, `recov_err` and `rsp_valid` are 0 and `cmd_ready` is 1.
- R2: `asleep` rises on the 4th rising edge after `sleep_req` goes high: two synchroniser edges, then an entry delay of two cycles.
- R3: `asleep` falls on the 3rd rising edge after `sleep_req` goes low. `recovering` rises on that same edge and stays high for exactly 2 cycles.
- R4: While `asleep` is high, `cmd_ready` is 0 and `cmd_block` is 1. A command presented during sleep changes neither the array nor any output.
- R5: While `asleep` is high, `dq_off` is 1, `rsp_valid` is 0 and `rsp_data` is 0. A result that was still waiting when sleep began is presented again, unchanged, after wake-up.
- R6: Array contents written before sleep read back unchanged after wake-up.
- R7: While `recovering` is high, reads are served normally. A write command (op 2 or 3) accepted in that window is not performed and sets `recov_err`. `recov_err` stays set until reset.
- R8: Command encoding on `cmd_op` is: 0 deselect, 1 read, 2 write, 3 burst-begin write. Both write codes store `cmd_wdata` at `cmd_addr`. A read taken on one edge shows its data on `rsp_valid`/`rsp_data` from that edge onward.
- R9: A request that is high for only one clock cycle aborts during the entry delay and never raises `asleep`.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `cmd_ready` is 0 and `rsp_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 deselect, 1 read, 2 write, 3 burst-begin write |
| cmd_addr | input | ADDR_W | Array address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | DATA_W | Read result, zero while asleep |
| asleep | output | 1 | Sleep state reached |
| cmd_block | output | 1 | Command inputs are gated off |
| dq_off | output | 1 | Result outputs are forced off |
| recovering | output | 1 | Wake-up window, reads and deselects only |
| recov_err | output | 1 | Sticky: a write arrived during the wake-up window |

## Verification
The hardest case to reach from the ports is a write landing on exactly the last edge of the wake-up window. The window opens and closes a fixed number of edges after the asynchronous request falls. The stimulus therefore releases the request on a falling edge and counts edges. It offers a read on the first window cycle and a write on the second, then confirms that the error flag is set and that a later read of the same address returns the old data. A second hard case is a result that is still waiting when sleep begins. The bench creates it by stalling `rsp_ready` before requesting sleep.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_WRBEG = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_AWAKE,
    ST_ENTER,
    ST_SLEEP,
    ST_WAKE
  } pwr_st_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = sh_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_seq_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  output logic in_sleep,
  output logic in_wake
);
  localparam int MAXC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1) < 1 ? 1 : $clog2(MAXC + 1);

  pwr_st_e       st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_AWAKE: if (req_s) begin
          if (ENTRY_CYC <= 1) st_q <= ST_SLEEP;
          else begin
            st_q  <= ST_ENTER;
            cnt_q <= CW'(1);
          end
        end
        ST_ENTER: begin
          if (!req_s)                           st_q  <= ST_AWAKE;
          else if (cnt_q == CW'(ENTRY_CYC - 1)) st_q  <= ST_SLEEP;
          else                                  cnt_q <= cnt_q + CW'(1);
        end
        ST_SLEEP: if (!req_s) begin
          st_q  <= ST_WAKE;
          cnt_q <= CW'(1);
        end
        ST_WAKE: begin
          if (cnt_q == CW'(WAKE_CYC)) st_q  <= ST_AWAKE;
          else                        cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= ST_AWAKE;
      endcase
    end
  end

  assign in_sleep = (st_q == ST_SLEEP);
  assign in_wake  = (st_q == ST_WAKE);
endmodule

// File: rtl/sleep_cmd_gate.sv
module sleep_cmd_gate
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       in_sleep,
  input  logic       in_wake,
  input  logic       rsp_busy,
  input  logic       rsp_ready,
  output logic       take,
  output logic       rd_en,
  output logic       wr_en,
  output logic       err_q
);
  logic is_wr;

  assign take  = cmd_valid && !in_sleep && (!rsp_busy || rsp_ready);
  assign is_wr = (op_e'(cmd_op) == OP_WRITE) || (op_e'(cmd_op) == OP_WRBEG);
  assign rd_en = take && (op_e'(cmd_op) == OP_READ);
  assign wr_en = take && is_wr && !in_wake;

  always_ff @(posedge clk) begin
    if (!rst_n)                       err_q <= 1'b0;
    else if (take && is_wr && in_wake) err_q <= 1'b1;
  end
endmodule

// File: rtl/sleep_store.sv
module sleep_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drain,
  output logic              res_v,
  output logic [DATA_W-1:0] res_d
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_v <= 1'b0;
      res_d <= '0;
    end else if (rd_en) begin
      res_v <= 1'b1;
      res_d <= mem_q[addr];
    end else if (drain) begin
      res_v <= 1'b0;
    end
  end
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int SYNC_STG  = 2,
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              asleep,
  output logic              cmd_block,
  output logic              dq_off,
  output logic              recovering,
  output logic              recov_err
);
  logic req_s, in_sleep, in_wake;
  logic take, rd_en, wr_en, err_q;
  logic res_v;
  logic [DATA_W-1:0] res_d;

  sleep_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sleep_req), .q_sync(req_s)
  );

  sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s),
    .in_sleep(in_sleep), .in_wake(in_wake)
  );

  sleep_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .in_sleep(in_sleep), .in_wake(in_wake), .rsp_busy(res_v),
    .rsp_ready(rsp_ready), .take(take), .rd_en(rd_en), .wr_en(wr_en),
    .err_q(err_q)
  );

  sleep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(cmd_addr), .wdata(cmd_wdata),
    .drain(rsp_ready && !in_sleep), .res_v(res_v), .res_d(res_d)
  );

  assign cmd_ready  = !in_sleep && (!res_v || rsp_ready);
  assign rsp_valid  = res_v && !in_sleep;
  assign rsp_data   = in_sleep ? '0 : res_d;
  assign asleep     = in_sleep;
  assign cmd_block  = in_sleep;
  assign dq_off     = in_sleep;
  assign recovering = in_wake;
  assign recov_err  = err_q;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int DATA_W   = 16,
  parameter int WAKE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              asleep,
  input logic              cmd_block,
  input logic              dq_off,
  input logic              recovering,
  input logic              recov_err
);
  localparam int RW = $clog2(WAKE_CYC + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= '0;
    else if (recovering) run_q <= run_q + RW'(1);
    else                 run_q <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !asleep && !recovering && !recov_err); // R1
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n) asleep |-> !cmd_ready && cmd_block); // R4
  AST_SLEEP_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n) asleep |-> dq_off && !rsp_valid && rsp_data == '0); // R5
  AST_WAKE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n) $rose(recovering) |-> $past(asleep) && !asleep); // R3
  AST_WAKE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n) recovering |-> run_q < RW'(WAKE_CYC)); // R3
  AST_WAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n) $fell(recovering) |-> run_q == RW'(WAKE_CYC)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) recov_err |=> recov_err); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_ready |-> !cmd_ready); // R10
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && !rsp_ready && !asleep |=> asleep || $stable(rsp_data)); // R10
endmodule

bind sleep_seq sleep_seq_chk #(.DATA_W(DATA_W), .WAKE_CYC(WAKE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .asleep(asleep),
  .cmd_block(cmd_block), .dq_off(dq_off), .recovering(recovering),
  .recov_err(recov_err)
);

// File: tb/tb_sleep_seq.sv
module tb_sleep_seq;
  localparam int AW = 4;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, asleep, cmd_block, dq_off, recovering, recov_err;
  logic [DW-1:0] rsp_data;

  int checks = 0, errors = 0;
  logic [DW-1:0] shadow [1<<AW];
  logic [DW-1:0] expq [$];

  always #5 clk = ~clk;

  sleep_seq dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .asleep(asleep), .cmd_block(cmd_block),
    .dq_off(dq_off), .recovering(recovering), .recov_err(recov_err)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops expected read data when a result is handed over
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) chk(1'b0, "R8 unexpected result", 32'(rsp_data), 32'hx);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(rsp_data == e, "R8/R6 read data", 32'(rsp_data), 32'(e));
      end
    end
  end

  // driver: one command, waits for acceptance
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    if (op == 2'd1) expq.push_back(shadow[a]);
    if (op >= 2'd2) shadow[a] = d;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic enter_sleep();
    @(negedge clk); sleep_req = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic leave_sleep();
    @(negedge clk); sleep_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!asleep && !recovering && !recov_err, "R1 flags", {asleep, recovering, recov_err}, 0);
    chk(!rsp_valid && cmd_ready, "R1 channel", {rsp_valid, cmd_ready}, 1);

    // R8: both write codes, then reads
    for (int i = 0; i < 8; i++) issue((i % 2) ? 2'd3 : 2'd2, AW'(i), DW'(16'h1000 + i * 16'h0111));
    for (int i = 0; i < 8; i++) issue(2'd1, AW'(i), '0);
    issue(2'd0, AW'(3), 16'hdead);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R8 all results seen", expq.size(), 0);

    // R2: entry timing
    @(negedge clk); sleep_req = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(asleep == (k >= 4), "R2 entry edge", {28'd0, 4'(k)} << 8 | 32'(asleep), 32'(k >= 4));
    end
    chk(cmd_block && !cmd_ready, "R4 gating", {cmd_block, cmd_ready}, 2);
    chk(dq_off && !rsp_valid && rsp_data == 0, "R5 outputs off", {dq_off, rsp_valid}, 2);

    // R4: commands offered while asleep
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_addr = AW'(2); cmd_wdata = 16'hbad0;
    repeat (3) @(negedge clk);
    chk(!cmd_ready, "R4 refused while asleep", cmd_ready, 0);
    cmd_valid = 1'b0;

    // R3: exit timing
    @(negedge clk); sleep_req = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk(recovering == (k == 3 || k == 4), "R3 wake window", 32'(recovering), 32'(k == 3 || k == 4));
      chk(asleep == (k < 3), "R3 sleep clears", 32'(asleep), 32'(k < 3));
    end
    chk(!recov_err, "R7 no error from clean wake", recov_err, 0);

    // R6 and R4: contents retained, asleep write had no effect
    for (int i = 0; i < 8; i++) issue(2'd1, AW'(i), '0);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R6 retained reads done", expq.size(), 0);

    // R10 and R5: a stalled result held across sleep
    issue(2'd2, AW'(9), 16'h5a5a);
    rsp_ready = 1'b0;
    issue(2'd1, AW'(9), '0);
    @(negedge clk);
    chk(rsp_valid && !cmd_ready, "R10 stall blocks commands", {rsp_valid, cmd_ready}, 2);
    chk(rsp_data == 16'h5a5a, "R10 held data", rsp_data, 16'h5a5a);
    enter_sleep();
    chk(asleep && !rsp_valid && rsp_data == 0, "R5 stalled result hidden", {asleep, rsp_valid}, 2);
    leave_sleep();
    chk(!asleep && rsp_valid && rsp_data == 16'h5a5a, "R5 stalled result back", rsp_data, 16'h5a5a);
    rsp_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R5 result delivered", expq.size(), 0);

    // R7: read then write inside the wake window
    enter_sleep();
    @(negedge clk); sleep_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(recovering, "R7 window open", recovering, 1);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = AW'(1);
    expq.push_back(shadow[1]);
    @(negedge clk);
    chk(recovering, "R7 window second cycle", recovering, 1);
    cmd_op = 2'd2; cmd_addr = AW'(2); cmd_wdata = 16'hbeef;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(recov_err && !recovering, "R7 error raised", {recov_err, recovering}, 2);
    issue(2'd1, AW'(2), '0);
    repeat (4) @(negedge clk);
    chk(recov_err, "R7 error sticky", recov_err, 1);
    chk(expq.size() == 0, "R7 reads in window served", expq.size(), 0);

    // R9: one-cycle request pulse
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (asleep || recovering) seen = 1'b1;
      end
      chk(!seen, "R9 short pulse ignored", seen, 0);
    end

    // R1/R7: reset clears the error
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!recov_err, "R1 reset clears error", recov_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule